// File: doc/BRIEF.md
# Active Video Edge Shaper

This block sits in a video encoder's pixel path. For each line it forms an active-video window from the horizontal pixel counter. It opens at a programmed start pixel and closes four pixels before the programmed end of the active region. It then softens the video at both edges of that window with a four-step amplitude ramp, so the picture never switches from blank to full level in a single pixel. Pixels outside the window are replaced by a programmable blank level.

The ramp has four variants, chosen by a 2-bit mode field:

- Mode 0 (`00`) weights the pixel stream itself.
- Mode 1 (`01`) captures one pixel, the fifth counted from the edge, and scales that single value through the four weights.
- Modes 2 and 3 (`1x`) apply no slope at all.

The weight set depends on the NTSC/PAL select. A direction bit decides how the window pin is used. When the bit is clear, the internal window is driven out on the pin. When it is set, the pin is an input that is ANDed into the window, and edges that the pin causes are ramped in the same way as internal ones.

All data moves only on pixel-strobe cycles. The output lags the input by six strobes, five of them in a look-ahead delay line, so mode 1 can know its captured pixel at the start of a ramp.

Top module: `avid_edge_shaper`

## Requirements
- R1: The internal window is high for pixel counts `start_cnt <= hcount < end_pos - 4`. `win_out` presents it one strobe after the count is sampled. `win_oe` is high exactly when `win_dir` is low, one clock after `win_dir` is sampled.
- R2: With `win_dir` = 1, the window that shapes the video is the internal window ANDed with `win_pin_in`. With `win_dir` = 0, `win_pin_in` has no effect on `pix_out`.
- R3: In mode `00`, the first four pixels at and after a rising window edge are multiplied by eighths {1,4,7,8} when `pal_sel` = 0, or {1,3,5,7} when `pal_sel` = 1.
- R4: In mode `00`, the four pixels at and after a falling edge are multiplied by the same eighths in reverse order: {8,7,4,1} for NTSC and {7,5,3,1} for PAL.
- R5: In mode `01`, each edge captures the pixel four strobes after the edge pixel. The ramp outputs that captured value scaled by the same weight order as R3 (rising edge) or R4 (falling edge).
- R6: When `ramp_mode[1]` = 1, there is no slope. The output is the delayed pixel while the window is high and `blank_level` while it is low.
- R7: Outside the window and outside any ramp, `pix_out` equals `blank_level`.
- R8: `pix_out` reflects the pixel presented six strobes earlier. `pix_out` and `win_out` hold while `pix_en` is low.
- R9: A window edge that arrives while a ramp is in progress restarts the sequence at step 0, in the new edge's direction.
- R10: Synchronous reset clears the ramp state and the delay line, and sets `pix_out`, `win_out` and `win_oe` to 0.
- R11: A scaled pixel equals floor(x·e/8) for 10-bit unsigned x and weight e in eighths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_en | input | 1 | Pixel strobe; state advances only when high |
| pix_in | input | 10 | Unsigned pixel data |
| hcount | input | 11 | Horizontal pixel counter |
| start_cnt | input | 11 | Pixel index at which the window opens |
| end_pos | input | 11 | End of active region; window closes four pixels earlier |
| ramp_mode | input | 2 | 00 ramp pixels, 01 ramp held fifth pixel, 1x no slope |
| pal_sel | input | 1 | 0 NTSC weight set, 1 PAL weight set |
| win_dir | input | 1 | 0 window pin is an output, 1 pin is an input gating the window |
| win_pin_in | input | 1 | Window pin level when used as input |
| blank_level | input | 10 | Value output for blanked pixels |
| pix_out | output | 10 | Shaped pixel data |
| win_out | output | 1 | Registered internal window for the pin |
| win_oe | output | 1 | Pin output enable |

## Verification
The bench toggles the external pin at random while the gated window is open. This creates windows only a pixel or two wide, so edges land inside running ramps. A design that finishes the old ramp instead of restarting would emit the wrong weight on the step after the new edge.

Full-scale and odd pixel values expose rounding: a design that rounds instead of truncating is off by one on weights such as 3/8 and 7/8.

Mode `01` is checked against the pixel four strobes after the edge. Holding the edge pixel, or the wrong tap, shows up as a flat but wrong level.

Gaps in the pixel strobe check that nothing shifts or counts on idle cycles.

// File: rtl/avid_shaper_pkg.sv
package avid_shaper_pkg;

  localparam int RAMP_LEN = 4;
  localparam int STEP_W   = $clog2(RAMP_LEN);

  typedef enum logic [1:0] {
    RM_PIXEL = 2'b00,
    RM_HOLD  = 2'b01,
    RM_OFF0  = 2'b10,
    RM_OFF1  = 2'b11
  } ramp_mode_e;

  // Weight in eighths for ramp step idx (rising order).
  function automatic logic [3:0] weight_eighths(input logic pal, input logic [STEP_W-1:0] idx);
    logic [3:0] w;
    case (idx)
      2'd0:    w = 4'd1;
      2'd1:    w = pal ? 4'd3 : 4'd4;
      2'd2:    w = pal ? 4'd5 : 4'd7;
      default: w = pal ? 4'd7 : 4'd8;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/avid_window_gen.sv
module avid_window_gen #(
  parameter int CW   = 11,
  parameter int EARLY = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_en,
  input  logic [CW-1:0] hcount,
  input  logic [CW-1:0] start_cnt,
  input  logic [CW-1:0] end_pos,
  input  logic          win_dir,
  input  logic          win_pin_in,
  output logic          win_eff,
  output logic          win_int_q,
  output logic          win_oe
);
  logic [CW:0] h_plus;
  logic        int_now;

  always_comb begin
    h_plus  = {1'b0, hcount} + (CW+1)'(EARLY);
    int_now = (hcount >= start_cnt) && (h_plus < {1'b0, end_pos});
    win_eff = int_now && (!win_dir || win_pin_in);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      win_int_q <= 1'b0;
      win_oe    <= 1'b0;
    end else begin
      win_oe <= !win_dir;
      if (pix_en) win_int_q <= int_now;
    end
  end
endmodule

// File: rtl/avid_delay_line.sv
module avid_delay_line #(
  parameter int W     = 11,
  parameter int DEPTH = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] tap_first,
  output logic [W-1:0] tap_last
);
  logic [W-1:0] stage [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) stage[0] <= '0;
    else if (en) stage[0] <= din;
  end

  for (genvar i = 1; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stage[i] <= '0;
      else if (en) stage[i] <= stage[i-1];
    end
  end

  assign tap_first = stage[0];
  assign tap_last  = stage[DEPTH-1];
endmodule

// File: rtl/avid_ramp_core.sv
module avid_ramp_core
  import avid_shaper_pkg::*;
#(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_en,
  input  logic [1:0]    ramp_mode,
  input  logic          pal_sel,
  input  logic [DW-1:0] blank_level,
  input  logic [DW-1:0] pix_first,
  input  logic [DW-1:0] pix_last,
  input  logic          win_last,
  output logic [DW-1:0] pix_out,
  output logic          win_prev,
  output logic          ramp_on
);
  localparam int SW = DW + 4;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(RAMP_LEN - 1);

  logic [STEP_W-1:0] cnt, step, idx;
  logic              ramp_dir, dir, edge_hit, use_ramp, slope_off, hold_mode;
  logic [DW-1:0]     hold_q, src, out_next;
  logic [3:0]        wgt;
  logic [SW-1:0]     prod;

  always_comb begin
    edge_hit  = (win_last != win_prev);
    slope_off = ramp_mode[1];
    hold_mode = (ramp_mode == RM_HOLD);
    step      = edge_hit ? '0 : cnt;
    use_ramp  = !slope_off && (edge_hit || ramp_on);
    dir       = edge_hit ? win_last : ramp_dir;
    idx       = dir ? step : (LAST_STEP - step);
    wgt       = weight_eighths(pal_sel, idx);
    src       = hold_mode ? (edge_hit ? pix_first : hold_q) : pix_last;
    // shift-and-add multiply by the eighths weight
    prod = (wgt[0] ? SW'(src)        : '0) +
           (wgt[1] ? (SW'(src) << 1) : '0) +
           (wgt[2] ? (SW'(src) << 2) : '0) +
           (wgt[3] ? (SW'(src) << 3) : '0);
    if (use_ramp)      out_next = DW'(prod >> 3);
    else if (win_last) out_next = pix_last;
    else               out_next = blank_level;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_out  <= '0;
      win_prev <= 1'b0;
      ramp_on  <= 1'b0;
      cnt      <= '0;
      ramp_dir <= 1'b0;
      hold_q   <= '0;
    end else if (pix_en) begin
      pix_out  <= out_next;
      win_prev <= win_last;
      if (edge_hit) begin
        ramp_dir <= win_last;
        hold_q   <= pix_first;
      end
      if (use_ramp) begin
        ramp_on <= (step != LAST_STEP);
        cnt     <= step + 1'b1;
      end
      if (slope_off) ramp_on <= 1'b0;
    end
  end
endmodule

// File: rtl/avid_edge_shaper.sv
module avid_edge_shaper
  import avid_shaper_pkg::*;
#(
  parameter int DW = 10,
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pix_en,
  input  logic [DW-1:0] pix_in,
  input  logic [CW-1:0] hcount,
  input  logic [CW-1:0] start_cnt,
  input  logic [CW-1:0] end_pos,
  input  logic [1:0]    ramp_mode,
  input  logic          pal_sel,
  input  logic          win_dir,
  input  logic          win_pin_in,
  input  logic [DW-1:0] blank_level,
  output logic [DW-1:0] pix_out,
  output logic          win_out,
  output logic          win_oe
);
  localparam int TAPS = RAMP_LEN + 1;
  localparam int LW   = DW + 1;

  logic          win_eff;
  logic [LW-1:0] tap_first, tap_last;
  logic          win_prev, ramp_on;

  avid_window_gen #(.CW(CW), .EARLY(RAMP_LEN)) u_win (
    .clk(clk), .rst(rst), .pix_en(pix_en), .hcount(hcount),
    .start_cnt(start_cnt), .end_pos(end_pos), .win_dir(win_dir),
    .win_pin_in(win_pin_in), .win_eff(win_eff), .win_int_q(win_out),
    .win_oe(win_oe)
  );

  avid_delay_line #(.W(LW), .DEPTH(TAPS)) u_dly (
    .clk(clk), .rst(rst), .en(pix_en), .din({win_eff, pix_in}),
    .tap_first(tap_first), .tap_last(tap_last)
  );

  avid_ramp_core #(.DW(DW)) u_core (
    .clk(clk), .rst(rst), .pix_en(pix_en), .ramp_mode(ramp_mode),
    .pal_sel(pal_sel), .blank_level(blank_level),
    .pix_first(tap_first[DW-1:0]), .pix_last(tap_last[DW-1:0]),
    .win_last(tap_last[DW]), .pix_out(pix_out), .win_prev(win_prev),
    .ramp_on(ramp_on)
  );
endmodule

// File: rtl/avid_edge_shaper_chk.sv
module avid_edge_shaper_chk #(
  parameter int DW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          pix_en,
  input logic [1:0]    ramp_mode,
  input logic          win_dir,
  input logic [DW-1:0] blank_level,
  input logic [DW-1:0] pix_out,
  input logic          win_out,
  input logic          win_oe,
  input logic [DW:0]   tap_last,
  input logic          win_prev,
  input logic          ramp_on
);
  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !pix_en |=> ($stable(pix_out) && $stable(win_out)));

  // R1
  pin_enable_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (win_oe == !$past(win_dir)));

  // R7
  blank_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_en && !tap_last[DW] && !win_prev && !ramp_on) |=> (pix_out == $past(blank_level)));

  // R6
  no_slope_chk: assert property (@(posedge clk) disable iff (rst)
    (pix_en && ramp_mode[1] && tap_last[DW]) |=> (pix_out == $past(tap_last[DW-1:0])));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (pix_out == '0 && !win_out && !win_oe));
endmodule

bind avid_edge_shaper avid_edge_shaper_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst(rst), .pix_en(pix_en), .ramp_mode(ramp_mode),
  .win_dir(win_dir), .blank_level(blank_level), .pix_out(pix_out),
  .win_out(win_out), .win_oe(win_oe), .tap_last(tap_last),
  .win_prev(win_prev), .ramp_on(ramp_on)
);

// File: tb/avid_edge_shaper_bench.sv
module avid_edge_shaper_bench;
  localparam int DW = 10;
  localparam int CW = 11;
  localparam int LINE = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pix_en = 1'b0;
  logic [DW-1:0] pix_in = '0;
  logic [CW-1:0] hcount = '0;
  logic [CW-1:0] start_cnt = 11'd8;
  logic [CW-1:0] end_pos = 11'd30;
  logic [1:0] ramp_mode = 2'b00;
  logic pal_sel = 1'b0;
  logic win_dir = 1'b0;
  logic win_pin_in = 1'b0;
  logic [DW-1:0] blank_level = '0;
  logic [DW-1:0] pix_out;
  logic win_out, win_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  avid_edge_shaper u_avid_edge_shaper (
    .clk(clk), .rst(rst), .pix_en(pix_en), .pix_in(pix_in), .hcount(hcount),
    .start_cnt(start_cnt), .end_pos(end_pos), .ramp_mode(ramp_mode),
    .pal_sel(pal_sel), .win_dir(win_dir), .win_pin_in(win_pin_in),
    .blank_level(blank_level), .pix_out(pix_out), .win_out(win_out), .win_oe(win_oe)
  );

  always #4 clk = ~clk;

  // reference model state
  int mp[5];
  bit mw[5];
  bit mprev, mon, mdir;
  int mcnt, mhold;
  int exp_pix = 0;
  bit exp_win = 0;
  string exp_tag = "R10";
  int hc = 0;

  function automatic int wt(bit pal, int idx);
    int n[4] = '{1, 4, 7, 8};
    int p[4] = '{1, 3, 5, 7};
    return pal ? p[idx] : n[idx];
  endfunction

  function automatic bit int_win(int h);
    return (h >= int'(start_cnt)) && (h + 4 < int'(end_pos));
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 5; i++) begin mp[i] = 0; mw[i] = 0; end
    mprev = 0; mon = 0; mdir = 0; mcnt = 0; mhold = 0;
    exp_pix = 0; exp_win = 0; exp_tag = "R10";
  endtask

  task automatic model_strobe(int pin_val, int h);
    int lp, fp, st, idx, src;
    bit lw, edge_hit, use_r, dir;
    lp = mp[4]; lw = mw[4]; fp = mp[0];
    edge_hit = (lw != mprev);
    st = edge_hit ? 0 : mcnt;
    use_r = !ramp_mode[1] && (edge_hit || mon);
    dir = edge_hit ? lw : mdir;
    idx = dir ? st : 3 - st;
    src = (ramp_mode == 2'b01) ? (edge_hit ? fp : mhold) : lp;
    if (use_r) begin
      exp_pix = (src * wt(pal_sel, idx)) / 8;   // R11 truncation
      if (edge_hit && mon) exp_tag = "R9";
      else if (ramp_mode == 2'b01) exp_tag = "R5";
      else exp_tag = dir ? "R3" : "R4";
    end else if (lw) begin
      exp_pix = lp; exp_tag = ramp_mode[1] ? "R6" : "R8";
    end else begin
      exp_pix = int'(blank_level); exp_tag = win_dir ? "R2" : "R7";
    end
    mprev = lw;
    if (edge_hit) begin mdir = lw; mhold = fp; end
    if (use_r) begin mon = (st != 3); mcnt = (st + 1) % 4; end
    if (ramp_mode[1]) mon = 0;
    for (int i = 4; i > 0; i--) begin mp[i] = mp[i-1]; mw[i] = mw[i-1]; end
    mp[0] = pin_val;
    mw[0] = int_win(h) && (!win_dir || win_pin_in);
    exp_win = int_win(h);
  endtask

  task automatic check_outputs();
    checks++;
    if (int'(pix_out) != exp_pix) begin
      errors++;
      $display("FAIL %s pix_out actual %0d expected %0d", exp_tag, pix_out, exp_pix);
    end
    checks++;
    if (win_out != exp_win) begin
      errors++;
      $display("FAIL R1 win_out actual %0b expected %0b", win_out, exp_win);
    end
    checks++;
    if (win_oe != !win_dir) begin
      errors++;
      $display("FAIL R1 win_oe actual %0b expected %0b", win_oe, !win_dir);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; pix_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    model_reset();
    hc = 0;
    // R10: outputs cleared by reset
    checks++;
    if (pix_out != '0 || win_out != 1'b0 || win_oe != 1'b0) begin
      errors++;
      $display("FAIL R10 reset outputs actual %0d/%0b/%0b expected 0/0/0", pix_out, win_out, win_oe);
    end
  endtask

  task automatic run_phase(int n, int en_pct, bit pin_rand);
    for (int k = 0; k < n; k++) begin
      int v;
      bit en;
      @(negedge clk);
      if (k > 0) check_outputs();
      v = $urandom_range(0, 1023);
      if ($urandom_range(0, 9) == 0) v = 1023;
      else if ($urandom_range(0, 9) == 0) v = 1;
      en = ($urandom_range(0, 99) < en_pct);
      if (pin_rand) win_pin_in = ($urandom_range(0, 3) != 0);
      else win_pin_in = $urandom_range(0, 1);
      pix_in = DW'(v);
      hcount = CW'(hc);
      pix_en = en;
      if (en) begin
        model_strobe(v, hc);
        hc = (hc + 1) % LINE;
      end
    end
    @(negedge clk);
    check_outputs();
    pix_en = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h5eed_2193));
    do_reset();
    // R3 R4 NTSC mode 00, pin ignored (R2)
    ramp_mode = 2'b00; pal_sel = 0; win_dir = 0;
    run_phase(200, 100, 0);
    // R3 R4 PAL weights, strobe gaps (R8)
    pal_sel = 1;
    run_phase(200, 70, 0);
    // R5 held fifth pixel
    ramp_mode = 2'b01; pal_sel = 0;
    run_phase(200, 85, 0);
    pal_sel = 1;
    run_phase(200, 100, 0);
    // R6 no slope, R7 nonzero blank level
    ramp_mode = 2'b10; blank_level = 10'd64;
    run_phase(150, 90, 0);
    ramp_mode = 2'b11;
    run_phase(150, 90, 0);
    // R10 reset mid-run, then R2 R9 gated window with random pin
    do_reset();
    ramp_mode = 2'b00; pal_sel = 0; win_dir = 1; blank_level = 10'd16;
    run_phase(300, 90, 1);
    ramp_mode = 2'b01; pal_sel = 1;
    run_phase(300, 90, 1);
    // narrow window: start 10, end 16 -> two-pixel window, R9 restart
    ramp_mode = 2'b00; win_dir = 0; start_cnt = 11'd10; end_pos = 11'd16;
    run_phase(200, 100, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule